// File: doc/BRIEF.md
# Register Bank Slave with Selectable Write-Strobe Policy

This block is a memory-mapped register slave on an AXI4-Lite port. It holds a small bank of 32-bit registers, and each register is reached through a word address. All five channels are present: write address, write data, write response, read address and read data. Each channel has its own VALID/READY handshake. Every access is a single beat as wide as the data bus. A write is committed once both its address and its data have been taken in, and the two may arrive in either order.

The parameter `STRB_MODE` picks how byte strobes are handled. Mode 0 updates only the enabled bytes. Mode 1 treats any non-empty strobe as a full-word write. Mode 2 accepts only the full-word pattern and answers every other non-empty pattern with an error. A write with no strobe bit set is always caught before the policy applies. The parameter `ZERO_STRB_OK` decides whether that write finishes as a harmless no-op or is refused. Addresses past the end of the bank are decoded as errors and change nothing. Every handshake and response output comes straight from a flop, so no path runs from an input to an output.

Top module: `lite_regbank`

## Requirements
- R1: A beat moves on a channel only in a cycle where both VALID and READY are high on that channel. Each accepted read address produces one read response, and each accepted address/data pair produces one write response. Responses come back in acceptance order.
- R2: Write address and write data are taken in independently, in either order or in the same cycle. The register changes and BVALID rises on the clock edge after the later of the two is accepted. While one half is still missing, BVALID stays low and the register keeps its old value. AWREADY and WREADY stay low while a write response is pending.
- R3: Once BVALID is high, BVALID and BRESP stay unchanged until the cycle in which BREADY is high.
- R4: RVALID rises on the clock edge that accepts the read address. RVALID, RDATA and RRESP then stay unchanged until RREADY is seen. ARREADY stays low while a read response is pending.
- R5: With `STRB_MODE`=0, strobe bit n updates only data bits 8n+7..8n of the addressed register, and the response is OKAY.
- R6: With `STRB_MODE`=1, any non-zero strobe writes all 32 bits, and the response is OKAY.
- R7: With `STRB_MODE`=2, strobe 4'b1111 writes the whole word with OKAY. Any other non-zero strobe returns SLVERR and leaves the register unchanged.
- R8: A strobe of 4'b0000 never changes a register, in any mode. It returns OKAY when `ZERO_STRB_OK`=1 and SLVERR when `ZERO_STRB_OK`=0.
- R9: The register index is address bits [ADDR_W-1:2], and bits [1:0] are ignored. An index of `NUM_REGS` or more returns DECERR on writes and on reads, gives RDATA of zero, and modifies no register. The address check takes priority over the strobe checks.
- R10: The response encodings are OKAY=2'b00, SLVERR=2'b10 and DECERR=2'b11. The value 2'b01 is never returned.
- R11: While reset is high, and on the first clock edge after it, BVALID, RVALID and all READY outputs are low. AWREADY, WREADY and ARREADY rise on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte strobes, bit n for bits 8n+7..8n |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |

## Verification
The assertions assume the master keeps each VALID high, with stable address, data and strobes, until its handshake, and never drops a request it has started. The bench drives every request from negative-edge tasks and holds it until a READY seen at a negative edge has been consumed by the following rising edge. BREADY and RREADY are raised only after their VALID is seen, and sometimes several cycles later, so the hold-until-ready rules are exercised. Three instances with different strobe policies receive the same stimulus, and each one is compared against its own arithmetic model.

// File: rtl/lite_regbank_pkg.sv
package lite_regbank_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  localparam int STRB_HONOUR = 0;
  localparam int STRB_IGNORE = 1;
  localparam int STRB_REJECT = 2;
endpackage

// File: rtl/lite_reg_store.sv
module lite_reg_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_sel,
  input  logic                rd_hit,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [DATA_W-1:0] rd_q;

  // byte-enabled write port, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) mem[wr_sel][l*8 +: 8] <= wr_data[l*8 +: 8];
      end
    end
  end

  // registered read port; a miss loads zero
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_hit ? mem[rd_sel] : '0;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/lite_wr_path.sv
module lite_wr_path
  import lite_regbank_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int NUM_REGS     = 8,
  parameter int STRB_MODE    = STRB_HONOUR,
  parameter bit ZERO_STRB_OK = 1'b1,
  parameter int SEL_W        = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                awvalid,
  output logic                awready,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                wvalid,
  output logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic                bvalid,
  input  logic                bready,
  output logic [1:0]          bresp,
  output logic                wr_en,
  output logic [SEL_W-1:0]    wr_sel,
  output logic [DATA_W/8-1:0] wr_be,
  output logic [DATA_W-1:0]   wr_data
);
  localparam int STRB_W = DATA_W / 8;
  localparam int IDX_W  = ADDR_W - 2;

  logic              aw_held_q, w_held_q, bvalid_q, awready_q, wready_q;
  logic [IDX_W-1:0]  aw_idx_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  resp_e             bresp_q;

  logic aw_fire, w_fire, b_fire, commit;
  logic aw_held_n, w_held_n, bvalid_n;

  assign aw_fire = awvalid & awready_q;
  assign w_fire  = wvalid & wready_q;
  assign b_fire  = bvalid_q & bready;
  assign commit  = aw_held_q & w_held_q;

  assign aw_held_n = ~commit & (aw_held_q | aw_fire);
  assign w_held_n  = ~commit & (w_held_q | w_fire);
  assign bvalid_n  = commit | (bvalid_q & ~b_fire);

  // address decode of the held request
  logic hit;
  assign hit = {1'b0, aw_idx_q} < (IDX_W + 1)'(NUM_REGS);

  // strobe policy variant
  logic [STRB_W-1:0] pol_be;
  logic              pol_err;
  if (STRB_MODE == STRB_IGNORE) begin : g_ignore
    assign pol_be  = '1;
    assign pol_err = 1'b0;
  end else if (STRB_MODE == STRB_REJECT) begin : g_reject
    assign pol_err = ~&w_strb_q;
    assign pol_be  = pol_err ? '0 : '1;
  end else begin : g_honour
    assign pol_be  = w_strb_q;
    assign pol_err = 1'b0;
  end

  resp_e             resp_c;
  logic [STRB_W-1:0] be_c;
  always_comb begin
    resp_c = RESP_OKAY;
    be_c   = '0;
    if (!hit) begin
      resp_c = RESP_DECERR;
    end else if (w_strb_q == '0) begin
      resp_c = ZERO_STRB_OK ? RESP_OKAY : RESP_SLVERR;
    end else if (pol_err) begin
      resp_c = RESP_SLVERR;
    end else begin
      be_c = pol_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      awready_q <= 1'b0;
      wready_q  <= 1'b0;
      bresp_q   <= RESP_OKAY;
    end else begin
      aw_held_q <= aw_held_n;
      w_held_q  <= w_held_n;
      bvalid_q  <= bvalid_n;
      awready_q <= ~aw_held_n & ~bvalid_n;
      wready_q  <= ~w_held_n & ~bvalid_n;
      if (commit) bresp_q <= resp_c;
    end
  end

  always_ff @(posedge clk) begin
    if (aw_fire) aw_idx_q <= awaddr[ADDR_W-1:2];
    if (w_fire) begin
      w_data_q <= wdata;
      w_strb_q <= wstrb;
    end
  end

  assign awready = awready_q;
  assign wready  = wready_q;
  assign bvalid  = bvalid_q;
  assign bresp   = bresp_q;
  assign wr_en   = commit & (|be_c);
  assign wr_sel  = aw_idx_q[SEL_W-1:0];
  assign wr_be   = be_c;
  assign wr_data = w_data_q;
endmodule

// File: rtl/lite_rd_path.sv
module lite_rd_path
  import lite_regbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [1:0]        rresp,
  output logic              rd_en,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              rd_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic  arready_q, rvalid_q;
  resp_e rresp_q;
  logic  ar_fire, r_fire, rvalid_n;
  logic [IDX_W-1:0] idx;

  assign ar_fire  = arvalid & arready_q;
  assign r_fire   = rvalid_q & rready;
  assign rvalid_n = ar_fire | (rvalid_q & ~r_fire);
  assign idx      = araddr[ADDR_W-1:2];
  assign rd_hit   = {1'b0, idx} < (IDX_W + 1)'(NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      arready_q <= 1'b0;
      rvalid_q  <= 1'b0;
      rresp_q   <= RESP_OKAY;
    end else begin
      rvalid_q  <= rvalid_n;
      arready_q <= ~rvalid_n;
      if (ar_fire) rresp_q <= rd_hit ? RESP_OKAY : RESP_DECERR;
    end
  end

  assign arready = arready_q;
  assign rvalid  = rvalid_q;
  assign rresp   = rresp_q;
  assign rd_en   = ar_fire;
  assign rd_sel  = idx[SEL_W-1:0];
endmodule

// File: rtl/lite_regbank.sv
module lite_regbank
  import lite_regbank_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int NUM_REGS     = 8,
  parameter int STRB_MODE    = STRB_HONOUR,
  parameter bit ZERO_STRB_OK = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp
);
  localparam int SEL_W  = $clog2(NUM_REGS);
  localparam int STRB_W = DATA_W / 8;

  logic              wr_en, rd_en, rd_hit;
  logic [SEL_W-1:0]  wr_sel, rd_sel;
  logic [STRB_W-1:0] wr_be;
  logic [DATA_W-1:0] wr_data;

  lite_wr_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .STRB_MODE(STRB_MODE), .ZERO_STRB_OK(ZERO_STRB_OK), .SEL_W(SEL_W)
  ) wr_i (
    .clk(clk), .rst(rst),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data)
  );

  lite_rd_path #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) rd_i (
    .clk(clk), .rst(rst),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rresp(s_rresp),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_hit(rd_hit)
  );

  lite_reg_store #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) store_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_hit(rd_hit), .rd_data(s_rdata)
  );
endmodule

// File: rtl/lite_regbank_chk.sv
module lite_regbank_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [ADDR_W-1:0] s_araddr,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp
);
  logic aw_seen, w_seen;
  logic rst_d = 1'b0;
  logic ar_hit;

  assign ar_hit = {1'b0, s_araddr[ADDR_W-1:2]} < (ADDR_W - 1)'(NUM_REGS);

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      aw_seen <= 1'b0;
      w_seen  <= 1'b0;
    end else begin
      if (s_bvalid && s_bready) begin
        aw_seen <= 1'b0;
        w_seen  <= 1'b0;
      end else begin
        if (s_awvalid && s_awready) aw_seen <= 1'b1;
        if (s_wvalid && s_wready)   w_seen  <= 1'b1;
      end
    end
  end

  assert_b_after_both_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(s_bvalid) |-> (aw_seen && w_seen));

  assert_no_accept_during_b_R2: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> (!s_awready && !s_wready));

  assert_b_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

  assert_r_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

  assert_ar_block_R4: assert property (@(posedge clk) disable iff (rst)
    s_rvalid |-> !s_arready);

  assert_rd_decode_R9: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_arready) |=>
      (s_rvalid && (s_rresp == ($past(ar_hit) ? 2'b00 : 2'b11))));

  assert_resp_code_R10: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid |-> s_bresp != 2'b01) and (s_rvalid |-> s_rresp != 2'b01));

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_quiet_R11: assert (!s_bvalid && !s_rvalid && !s_awready
                                      && !s_wready && !s_arready);
    end
  end
endmodule

bind lite_regbank lite_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) chk_i (
  .clk(clk), .rst(rst),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
);

// File: tb/lite_regbank_tb_top.sv
module lite_regbank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [7:0] awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;

  logic        awready_v [3], wready_v [3], bvalid_v [3], arready_v [3], rvalid_v [3];
  logic [1:0]  bresp_v [3], rresp_v [3];
  logic [31:0] rdata_v [3];

  logic [1:0]  cap_resp [3];
  logic [31:0] cap_data [3];
  logic [31:0] shadow [3][8];

  int n_chk = 0;
  int n_bad = 0;

  // instance k: 0 honour/zero-ok, 1 ignore/zero-ok, 2 reject/zero-refused
  lite_regbank #(.STRB_MODE(0), .ZERO_STRB_OK(1'b1)) dut_i (
    .clk(clk), .rst(rst),
    .s_awvalid(awvalid), .s_awready(awready_v[0]), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready_v[0]), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid_v[0]), .s_bready(bready), .s_bresp(bresp_v[0]),
    .s_arvalid(arvalid), .s_arready(arready_v[0]), .s_araddr(araddr),
    .s_rvalid(rvalid_v[0]), .s_rready(rready), .s_rdata(rdata_v[0]), .s_rresp(rresp_v[0]));

  lite_regbank #(.STRB_MODE(1), .ZERO_STRB_OK(1'b1)) dut_ign (
    .clk(clk), .rst(rst),
    .s_awvalid(awvalid), .s_awready(awready_v[1]), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready_v[1]), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid_v[1]), .s_bready(bready), .s_bresp(bresp_v[1]),
    .s_arvalid(arvalid), .s_arready(arready_v[1]), .s_araddr(araddr),
    .s_rvalid(rvalid_v[1]), .s_rready(rready), .s_rdata(rdata_v[1]), .s_rresp(rresp_v[1]));

  lite_regbank #(.STRB_MODE(2), .ZERO_STRB_OK(1'b0)) dut_rej (
    .clk(clk), .rst(rst),
    .s_awvalid(awvalid), .s_awready(awready_v[2]), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready_v[2]), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid_v[2]), .s_bready(bready), .s_bresp(bresp_v[2]),
    .s_arvalid(arvalid), .s_arready(arready_v[2]), .s_araddr(araddr),
    .s_rvalid(rvalid_v[2]), .s_rready(rready), .s_rdata(rdata_v[2]), .s_rresp(rresp_v[2]));

  function automatic logic [31:0] exp_val(int k, logic [31:0] old, logic [31:0] nw,
                                          logic [3:0] s);
    logic [31:0] m;
    if (s == 4'h0) return old;
    if (k == 1) return nw;
    if (k == 2) return (s == 4'hF) ? nw : old;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = s[b] ? 8'hFF : 8'h00;
    return (nw & m) | (old & ~m);
  endfunction

  function automatic logic [1:0] exp_resp(int k, logic [3:0] s);
    if (s == 4'h0) return (k == 2) ? 2'b10 : 2'b00;
    if (k == 2 && s != 4'hF) return 2'b10;
    return 2'b00;
  endfunction

  task automatic ck(input string tag, input int k, input logic [31:0] act,
                    input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d: got %h expected %h", tag, k, act, exp);
    end
  endtask

  task automatic send_aw(input logic [7:0] a, input int d);
    repeat (d) @(negedge clk);
    awaddr = a; awvalid = 1'b1;
    while (!(awready_v[0] && awready_v[1] && awready_v[2])) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
  endtask

  task automatic send_w(input int d);
    repeat (d) @(negedge clk);
    wvalid = 1'b1;
    while (!(wready_v[0] && wready_v[1] && wready_v[2])) @(negedge clk);
    @(negedge clk);
    wvalid = 1'b0;
  endtask

  task automatic take_b(input int d);
    while (!(bvalid_v[0] && bvalid_v[1] && bvalid_v[2])) @(negedge clk);
    for (int k = 0; k < 3; k++) cap_resp[k] = bresp_v[k];
    repeat (d) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        ck("R3 bvalid held", k, 32'(bvalid_v[k]), 32'd1);
        ck("R3 bresp held", k, 32'(bresp_v[k]), 32'(cap_resp[k]));
        ck("R2 awready low while b pending", k, 32'(awready_v[k]), 32'd0);
      end
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] dat, input logic [3:0] s,
                    input int order, input int bd);
    wdata = dat; wstrb = s;
    fork
      send_aw(a, (order == 2) ? 3 : 0);
      send_w((order == 1) ? 3 : 0);
    join
    take_b(bd);
  endtask

  task automatic rd(input logic [7:0] a, input int d);
    araddr = a; arvalid = 1'b1;
    while (!(arready_v[0] && arready_v[1] && arready_v[2])) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    while (!(rvalid_v[0] && rvalid_v[1] && rvalid_v[2])) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      cap_data[k] = rdata_v[k];
      cap_resp[k] = rresp_v[k];
    end
    repeat (d) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        ck("R4 rdata held", k, rdata_v[k], cap_data[k]);
        ck("R4 arready low while r pending", k, 32'(arready_v[k]), 32'd0);
      end
    end
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] base, nw;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      ck("R11 bvalid in reset", k, 32'(bvalid_v[k]), 0);
      ck("R11 rvalid in reset", k, 32'(rvalid_v[k]), 0);
      ck("R11 awready in reset", k, 32'(awready_v[k]), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      ck("R11 awready after release", k, 32'(awready_v[k]), 1);
      ck("R11 arready after release", k, 32'(arready_v[k]), 1);
      ck("R11 bvalid after release", k, 32'(bvalid_v[k]), 0);
    end

    // sweep: every register, every strobe pattern, rotating arrival order
    for (int r = 0; r < 8; r++) begin
      for (int s = 0; s < 16; s++) begin
        base = {8'(r), 8'(s), 8'hC3, 8'h5A};
        nw   = ~base;
        wr(8'(r * 4), base, 4'hF, (r + s) % 3, s % 3);
        for (int k = 0; k < 3; k++) begin
          ck("R1 baseline bresp", k, 32'(cap_resp[k]), 32'd0);
          shadow[k][r] = base;
        end
        wr(8'(r * 4), nw, 4'(s), (r + s + 1) % 3, (r + s) % 4);
        for (int k = 0; k < 3; k++) begin
          ck("R5 R6 R7 R8 R10 strobe bresp", k, 32'(cap_resp[k]), 32'(exp_resp(k, 4'(s))));
          shadow[k][r] = exp_val(k, shadow[k][r], nw, 4'(s));
        end
        rd(8'(r * 4), (r + s) % 3);
        for (int k = 0; k < 3; k++) begin
          ck("R5 R6 R7 R8 readback", k, cap_data[k], shadow[k][r]);
          ck("R1 read resp", k, 32'(cap_resp[k]), 32'd0);
        end
      end
    end

    // out-of-range indices: DECERR, zero data, no aliasing
    for (int i = 8; i < 16; i++) begin
      wr(8'(i * 4), 32'hDEAD_0000 + 32'(i), 4'hF, i % 3, 1);
      for (int k = 0; k < 3; k++) ck("R9 write decerr", k, 32'(cap_resp[k]), 32'd3);
      rd(8'(i * 4), 1);
      for (int k = 0; k < 3; k++) begin
        ck("R9 read decerr", k, 32'(cap_resp[k]), 32'd3);
        ck("R9 read zero", k, cap_data[k], 32'd0);
      end
      rd(8'((i - 8) * 4), 0);
      for (int k = 0; k < 3; k++) ck("R9 no side effect", k, cap_data[k], shadow[k][i - 8]);
    end

    // low address bits ignored
    wr(8'h0B, 32'h1234_5678, 4'hF, 0, 0);
    for (int k = 0; k < 3; k++) shadow[k][2] = 32'h1234_5678;
    rd(8'h09, 0);
    for (int k = 0; k < 3; k++) ck("R9 low bits ignored", k, cap_data[k], 32'h1234_5678);

    // half-accepted writes: address first, then data first
    for (int v = 0; v < 2; v++) begin
      wdata = 32'hA000_0000 + 32'(v); wstrb = 4'hF;
      if (v == 0) send_aw(8'h0C, 0); else send_w(0);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 3; k++) ck("R2 no bvalid on half request", k, 32'(bvalid_v[k]), 0);
      rd(8'h0C, 0);
      for (int k = 0; k < 3; k++) ck("R2 register untouched", k, cap_data[k], shadow[k][3]);
      if (v == 0) send_w(0); else send_aw(8'h0C, 0);
      take_b(0);
      for (int k = 0; k < 3; k++) begin
        ck("R2 bresp after completion", k, 32'(cap_resp[k]), 32'd0);
        shadow[k][3] = 32'hA000_0000 + 32'(v);
      end
      rd(8'h0C, 0);
      for (int k = 0; k < 3; k++) ck("R2 register updated", k, cap_data[k], shadow[k][3]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule